// File: doc/BRIEF.md
# Multi-threaded page table walker

This block is the shared walker behind several per-unit translation buffers. Each miss request carries a virtual address and a requester ID. The walker places each miss in a buffer of its own and walks a four-level radix page table for it, starting from a root page number. Every buffer records the base of the table it is currently reading and the level it has reached. Table reads go out over a memory request channel that has handshaking and tags. Read data returns on a separate response channel, and it may come back in any order. When a walk reaches the leaf, the walker reports the physical page number and the requester ID on a one-cycle completion output.

A table entry with its present bit clear is a page fault. The walk stops and its buffer is parked. Parked walks take turns owning a single fault register. The register holds the faulting virtual address and raises a level interrupt towards the host. Once the host has repaired the table, it pulses a handler-done input with the same page address. The owning buffer then walks again from the root. If that second walk succeeds, the translation is returned and the register is released to the next parked walk, if there is one. If the second walk faults again, the interrupt is re-raised for the same address.

Top module: `ptw_walker`

## Requirements
- R1: After reset, miss_ready_o is 1, and mreq_valid_o, done_valid_o and fault_irq_o are 0.
- R2: miss_ready_o is 1 exactly when at least one of the NUM_SLOTS (32) buffers is free. An accepted miss goes into the lowest-numbered free buffer, so the block holds up to 32 walks at once.
- R3: Each walk reads one entry per level, from level 0 to level 3. The level-L index is va bits [47-9L : 39-9L]. The read address is {base_ppn, index, 3'b000}. The level-0 base is root_ppn_i. Each later base is entry bits [51:12]. A walk that succeeds makes exactly four reads.
- R4: mreq_tag_o is the index of the buffer that issued the read. A response is matched to its walk through mrsp_tag_i, and responses may arrive in any order. No tag is reissued while its read is still outstanding.
- R5: The cycle after the level-3 response of a present entry, done_valid_o is high for one cycle. done_ppn_o then equals entry bits [51:12], and done_id_o equals the requester ID of that miss.
- R6: Buffers waiting to issue a read are served round-robin. If four walks contend and each response returns in the cycle after its request, the first four grants name four different buffers, and each buffer appears exactly twice in the first eight grants.
- R7: An entry with bit 0 clear ends the walk with no completion. Only one faulting address is held at a time. fault_irq_o is 1 and fault_va_o holds that virtual address. Other faulting walks wait and take the register after it is released.
- R8: A fault_done_i pulse whose fault_done_va_i bits [47:12] match the held address starts a new walk from the root. fault_irq_o is 0 from the next cycle. A pulse that does not match issues no read and leaves the interrupt and the address unchanged.
- R9: If the second walk succeeds, its translation is returned and the fault register is released. If it faults again, fault_irq_o returns to 1 with the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| root_ppn_i | input | 40 | Physical page number of the level-0 table |
| miss_valid_i | input | 1 | Miss request valid |
| miss_ready_o | output | 1 | A buffer is free |
| miss_va_i | input | 48 | Virtual address to translate |
| miss_id_i | input | 4 | Requester ID |
| mreq_valid_o | output | 1 | Table read request valid |
| mreq_ready_i | input | 1 | Memory accepts the read |
| mreq_addr_o | output | 52 | Physical address of the entry |
| mreq_tag_o | output | 5 | Buffer index of the read |
| mrsp_valid_i | input | 1 | Read data valid |
| mrsp_tag_i | input | 5 | Tag of the returning read |
| mrsp_data_i | input | 64 | Entry data |
| done_valid_o | output | 1 | Translation complete |
| done_id_o | output | 4 | Requester ID of the completed walk |
| done_ppn_o | output | 40 | Translated physical page number |
| fault_irq_o | output | 1 | Fault pending, level interrupt |
| fault_va_o | output | 48 | Held faulting virtual address |
| fault_done_i | input | 1 | Host handler finished |
| fault_done_va_i | input | 48 | Address the handler served |

## Verification
The assertions assume that the memory returns data only for a tag whose read it has accepted, and only once for each read. They also assume that a handler-done pulse is a single cycle. The bench's memory model keeps a table of accepted tags. It answers only entries in that table, either at random or, in the round-robin test, in the cycle right after acceptance, and it clears each entry as it answers. Page-table contents are an arithmetic function of the entry address. Faults are injected by clearing the present bit of one computed entry address, and each handler-done pulse is driven for exactly one cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int IDX_W      = 9;
  localparam int LEVELS     = 4;
  localparam int LVL_W      = 2;
  localparam int PTE_W      = 64;

  typedef enum logic [1:0] {SLOT_FREE, SLOT_ISSUE, SLOT_WAIT, SLOT_PARK} slot_st_e;
  typedef enum logic [1:0] {FLT_IDLE, FLT_HELD, FLT_RECHECK} flt_st_e;
endpackage

// File: rtl/ptw_pick_first.sv
module ptw_pick_first #(
  parameter int N = 4,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end
endmodule

// File: rtl/ptw_rr_arb.sv
module ptw_rr_arb #(
  parameter int N = 4,
  parameter int W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         ack_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  logic [W-1:0] ptr_q;
  logic         hi_found, lo_found;
  logic [W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_found = 1'b0;
    lo_found = 1'b0;
    hi_idx   = '0;
    lo_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        lo_found = 1'b1;
        lo_idx   = W'(i);
        if (i >= int'(ptr_q)) begin
          hi_found = 1'b1;
          hi_idx   = W'(i);
        end
      end
    end
    found_o = lo_found;
    idx_o   = hi_found ? hi_idx : lo_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (ack_i && found_o) ptr_q <= (int'(idx_o) == N - 1) ? '0 : idx_o + 1'b1;
  end

  // R6: the grant always names a requesting buffer
  a_r6_grant_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> req_i[idx_o]);
  // R6: the consumer only acknowledges an offered grant
  a_r6_ack_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> found_o);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int ID_W      = 4,
  parameter int VA_W      = 48,
  parameter int PA_W      = 52,
  localparam int TAG_W    = $clog2(NUM_SLOTS),
  localparam int PPN_W    = PA_W - PAGE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PPN_W-1:0]  root_ppn_i,
  input  logic              miss_valid_i,
  output logic              miss_ready_o,
  input  logic [VA_W-1:0]   miss_va_i,
  input  logic [ID_W-1:0]   miss_id_i,
  output logic              mreq_valid_o,
  input  logic              mreq_ready_i,
  output logic [PA_W-1:0]   mreq_addr_o,
  output logic [TAG_W-1:0]  mreq_tag_o,
  input  logic              mrsp_valid_i,
  input  logic [TAG_W-1:0]  mrsp_tag_i,
  input  logic [PTE_W-1:0]  mrsp_data_i,
  output logic              done_valid_o,
  output logic [ID_W-1:0]   done_id_o,
  output logic [PPN_W-1:0]  done_ppn_o,
  output logic              fault_irq_o,
  output logic [VA_W-1:0]   fault_va_o,
  input  logic              fault_done_i,
  input  logic [VA_W-1:0]   fault_done_va_i
);
  slot_st_e          st_q  [NUM_SLOTS];
  logic [VA_W-1:0]   va_q  [NUM_SLOTS];
  logic [ID_W-1:0]   id_q  [NUM_SLOTS];
  logic [PPN_W-1:0]  ppn_q [NUM_SLOTS];
  logic [LVL_W-1:0]  lvl_q [NUM_SLOTS];

  logic [NUM_SLOTS-1:0] free_vec, issue_vec, park_vec;
  logic                 alloc_found, iss_found, park_found;
  logic [TAG_W-1:0]     alloc_idx, iss_idx, park_idx;

  flt_st_e          fst_q;
  logic [TAG_W-1:0] fslot_q;
  logic [VA_W-1:0]  fva_q;

  function automatic logic [IDX_W-1:0] lvl_index(logic [VA_W-1:0] va, logic [LVL_W-1:0] lvl);
    logic [VA_W-1:0] sh;
    sh = va >> (PAGE_SHIFT + IDX_W * (LEVELS - 1 - int'(lvl)));
    return sh[IDX_W-1:0];
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      free_vec[i]  = (st_q[i] == SLOT_FREE);
      issue_vec[i] = (st_q[i] == SLOT_ISSUE);
      park_vec[i]  = (st_q[i] == SLOT_PARK);
    end
  end

  ptw_pick_first #(.N(NUM_SLOTS), .W(TAG_W)) u_alloc (
    .req_i(free_vec), .found_o(alloc_found), .idx_o(alloc_idx));
  ptw_pick_first #(.N(NUM_SLOTS), .W(TAG_W)) u_park (
    .req_i(park_vec), .found_o(park_found), .idx_o(park_idx));

  logic iss_ack;
  assign iss_ack = iss_found && mreq_ready_i;

  ptw_rr_arb #(.N(NUM_SLOTS), .W(TAG_W)) u_arb (
    .clk_i, .rst_ni, .req_i(issue_vec), .ack_i(iss_ack),
    .found_o(iss_found), .idx_o(iss_idx));

  assign miss_ready_o = alloc_found;
  assign mreq_valid_o = iss_found;
  assign mreq_tag_o   = iss_idx;
  assign mreq_addr_o  = {ppn_q[iss_idx], lvl_index(va_q[iss_idx], lvl_q[iss_idx]), 3'b000};

  logic             accept, rsp_present, rsp_last, rewalk;
  logic [PPN_W-1:0] rsp_ppn;
  assign accept      = miss_valid_i && alloc_found;
  assign rsp_present = mrsp_data_i[0];
  assign rsp_ppn     = mrsp_data_i[PA_W-1:PAGE_SHIFT];
  assign rsp_last    = (lvl_q[mrsp_tag_i] == LVL_W'(LEVELS - 1));
  assign rewalk      = fault_done_i && (fst_q == FLT_HELD) &&
                       (fault_done_va_i[VA_W-1:PAGE_SHIFT] == fva_q[VA_W-1:PAGE_SHIFT]);

  logic unused_bits;
  assign unused_bits = ^{mrsp_data_i[PTE_W-1:PA_W], mrsp_data_i[PAGE_SHIFT-1:1],
                         fault_done_va_i[PAGE_SHIFT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        st_q[i]  <= SLOT_FREE;
        va_q[i]  <= '0;
        id_q[i]  <= '0;
        ppn_q[i] <= '0;
        lvl_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (accept && alloc_idx == TAG_W'(i)) begin
          st_q[i]  <= SLOT_ISSUE;
          va_q[i]  <= miss_va_i;
          id_q[i]  <= miss_id_i;
          ppn_q[i] <= root_ppn_i;
          lvl_q[i] <= '0;
        end
        if (iss_ack && iss_idx == TAG_W'(i)) st_q[i] <= SLOT_WAIT;
        if (mrsp_valid_i && mrsp_tag_i == TAG_W'(i)) begin
          if (!rsp_present)  st_q[i] <= SLOT_PARK;
          else if (rsp_last) st_q[i] <= SLOT_FREE;
          else begin
            st_q[i]  <= SLOT_ISSUE;
            ppn_q[i] <= rsp_ppn;
            lvl_q[i] <= lvl_q[i] + 1'b1;
          end
        end
        if (rewalk && fslot_q == TAG_W'(i)) begin
          st_q[i]  <= SLOT_ISSUE;
          ppn_q[i] <= root_ppn_i;
          lvl_q[i] <= '0;
        end
      end
    end
  end

  // single fault register, handed to one parked walk at a time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fst_q   <= FLT_IDLE;
      fslot_q <= '0;
      fva_q   <= '0;
    end else begin
      unique case (fst_q)
        FLT_IDLE: if (park_found) begin
          fst_q   <= FLT_HELD;
          fslot_q <= park_idx;
          fva_q   <= va_q[park_idx];
        end
        FLT_HELD: if (rewalk) fst_q <= FLT_RECHECK;
        FLT_RECHECK: if (mrsp_valid_i && mrsp_tag_i == fslot_q) begin
          if (!rsp_present)  fst_q <= FLT_HELD;
          else if (rsp_last) fst_q <= FLT_IDLE;
        end
        default: fst_q <= FLT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_valid_o <= 1'b0;
      done_id_o    <= '0;
      done_ppn_o   <= '0;
    end else begin
      done_valid_o <= mrsp_valid_i && rsp_present && rsp_last;
      done_id_o    <= id_q[mrsp_tag_i];
      done_ppn_o   <= rsp_ppn;
    end
  end

  assign fault_irq_o = (fst_q == FLT_HELD);
  assign fault_va_o  = fva_q;

  // R4: data only comes back for a buffer with a read outstanding
  a_r4_rsp_to_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrsp_valid_i |-> st_q[mrsp_tag_i] == SLOT_WAIT);
  // R5: a completion always follows a response by one cycle
  a_r5_done_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> $past(mrsp_valid_i));
  // R7: the held address does not change while the interrupt stays up
  a_r7_fault_va_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_irq_o && $past(fault_irq_o)) |-> $stable(fault_va_o));
  // R8: a matching handler-done drops the interrupt for the second walk
  a_r8_rewalk_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_irq_o && fault_done_i &&
     fault_done_va_i[VA_W-1:PAGE_SHIFT] == fault_va_o[VA_W-1:PAGE_SHIFT]) |=> !fault_irq_o);
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [39:0] ROOT = 40'h00_0012_3456;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0, miss_ready_o;
  logic [47:0] miss_va_i = '0;
  logic [3:0]  miss_id_i = '0;
  logic        mreq_valid_o, mreq_ready_i = 1'b0;
  logic [51:0] mreq_addr_o;
  logic [4:0]  mreq_tag_o;
  logic        mrsp_valid_i = 1'b0;
  logic [4:0]  mrsp_tag_i = '0;
  logic [63:0] mrsp_data_i = '0;
  logic        done_valid_o;
  logic [3:0]  done_id_o;
  logic [39:0] done_ppn_o;
  logic        fault_irq_o;
  logic [47:0] fault_va_o;
  logic        fault_done_i = 1'b0;
  logic [47:0] fault_done_va_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u0 (
    .clk_i(clk), .rst_ni, .root_ppn_i(ROOT),
    .miss_valid_i, .miss_ready_o, .miss_va_i, .miss_id_i,
    .mreq_valid_o, .mreq_ready_i, .mreq_addr_o, .mreq_tag_o,
    .mrsp_valid_i, .mrsp_tag_i, .mrsp_data_i,
    .done_valid_o, .done_id_o, .done_ppn_o,
    .fault_irq_o, .fault_va_o, .fault_done_i, .fault_done_va_i);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // page table: entry contents are a function of the entry address
  logic [51:0] bad0 = '0, bad1 = '0;
  bit          bad0_en = 0, bad1_en = 0;

  function automatic logic [63:0] pte(input logic [51:0] a);
    logic p;
    p = !((bad0_en && a == bad0) || (bad1_en && a == bad1));
    return {12'h0, a[43:4] ^ 40'h3C_5A96_0F1E, 11'h0, p};
  endfunction

  function automatic logic [8:0] vidx(input logic [47:0] va, input int l);
    logic [47:0] s;
    s = va >> (12 + 9 * (3 - l));
    return s[8:0];
  endfunction

  function automatic logic [51:0] entry_addr(input logic [47:0] va, input int lvl);
    logic [39:0] base;
    logic [51:0] a;
    logic [63:0] d;
    base = ROOT;
    a = '0;
    for (int l = 0; l <= lvl; l++) begin
      a = {base, vidx(va, l), 3'b000};
      d = pte(a);
      base = d[51:12];
    end
    return a;
  endfunction

  function automatic bit exp_walk(input logic [47:0] va, output logic [39:0] ppn);
    logic [39:0] base;
    logic [63:0] d;
    base = ROOT;
    ppn = '0;
    for (int l = 0; l < 4; l++) begin
      d = pte({base, vidx(va, l), 3'b000});
      if (!d[0]) return 1'b0;
      base = d[51:12];
    end
    ppn = base;
    return 1'b1;
  endfunction

  // scoreboard of sent misses
  logic [47:0] sb_va [0:511];
  logic [3:0]  sb_id [0:511];
  bit          sb_v  [0:511];
  int n_sent = 0, n_done = 0;

  // memory model state
  bit          pend_v [0:31];
  logic [51:0] pend_a [0:31];
  logic [51:0] log_a  [0:1023];
  logic [4:0]  log_t  [0:1023];
  int  nreq = 0;
  bit  mem_block = 1, fast = 0, fast_v = 0;
  logic [4:0] fast_t = '0;

  initial for (int i = 0; i < 32; i++) pend_v[i] = 0;

  always @(negedge clk) begin
    if (rst_ni && done_valid_o) begin
      bit found;
      logic [39:0] e;
      found = 0;
      for (int i = 0; i < n_sent; i++) begin
        if (!found && sb_v[i] && sb_id[i] == done_id_o && exp_walk(sb_va[i], e) && e == done_ppn_o) begin
          found = 1;
          sb_v[i] = 0;
        end
      end
      chk(found, "R5 completion ppn/id", {20'h0, done_id_o, done_ppn_o}, 64'h0);
      n_done++;
    end
    mrsp_valid_i = 1'b0;
    if (!mem_block) begin
      if (fast) begin
        if (fast_v) begin
          mrsp_valid_i = 1'b1;
          mrsp_tag_i   = fast_t;
          mrsp_data_i  = pte(pend_a[fast_t]);
          pend_v[fast_t] = 0;
        end
      end else if ($urandom % 2 == 0) begin
        int s;
        bit got;
        s = $urandom % 32;
        got = 0;
        for (int k = 0; k < 32; k++) begin
          int t;
          t = (s + k) % 32;
          if (!got && pend_v[t]) begin
            got = 1;
            mrsp_valid_i = 1'b1;
            mrsp_tag_i   = 5'(t);
            mrsp_data_i  = pte(pend_a[t]);
            pend_v[t] = 0;
          end
        end
      end
    end
    fast_v = 0;
    mreq_ready_i = mem_block ? 1'b0 : (fast ? 1'b1 : ($urandom % 4 != 0));
    if (rst_ni && mreq_ready_i && mreq_valid_o) begin
      if (pend_v[mreq_tag_o]) chk(0, "R4 tag reused while outstanding", 64'(mreq_tag_o), 64'h0);
      pend_v[mreq_tag_o] = 1;
      pend_a[mreq_tag_o] = mreq_addr_o;
      fast_v = 1;
      fast_t = mreq_tag_o;
      if (nreq < 1024) begin
        log_a[nreq] = mreq_addr_o;
        log_t[nreq] = mreq_tag_o;
      end
      nreq++;
    end
  end

  task automatic send_miss(input logic [47:0] va, input logic [3:0] id);
    while (!miss_ready_o) @(negedge clk);
    miss_valid_i = 1'b1;
    miss_va_i = va;
    miss_id_i = id;
    sb_va[n_sent] = va;
    sb_id[n_sent] = id;
    sb_v[n_sent]  = 1;
    n_sent++;
    @(negedge clk);
    miss_valid_i = 1'b0;
  endtask

  task automatic handler_done(input logic [47:0] va);
    fault_done_i = 1'b1;
    fault_done_va_i = va;
    @(negedge clk);
    fault_done_i = 1'b0;
  endtask

  function automatic logic [47:0] rand_va();
    return {$urandom, $urandom} & 48'hFFFF_FFFF_F000;
  endfunction

  initial begin
    logic [47:0] va, fa, fg, f1, f2;
    int base_req, base_done, cnt[4];
    bit distinct;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(miss_ready_o == 1, "R1 miss_ready_o", 64'(miss_ready_o), 1);
    chk(mreq_valid_o == 0, "R1 mreq_valid_o", 64'(mreq_valid_o), 0);
    chk(done_valid_o == 0, "R1 done_valid_o", 64'(done_valid_o), 0);
    chk(fault_irq_o == 0, "R1 fault_irq_o", 64'(fault_irq_o), 0);

    // R3 single walk address sequence, R4 tag of buffer 0
    mem_block = 0;
    va = 48'h7A5C_3B91_E000;
    send_miss(va, 4'd3);
    while (n_done != 1) @(negedge clk);
    chk(nreq == 4, "R3 read count", 64'(nreq), 4);
    for (int l = 0; l < 4; l++) begin
      chk(log_a[l] == entry_addr(va, l), "R3 entry address", 64'(log_a[l]), 64'(entry_addr(va, l)));
      chk(log_t[l] == 5'd0, "R4 tag is lowest free buffer", 64'(log_t[l]), 0);
    end

    // R2 capacity of 32 buffers
    mem_block = 1;
    for (int i = 0; i < 32; i++) send_miss(rand_va(), 4'($urandom));
    @(negedge clk);
    chk(miss_ready_o == 0, "R2 full deasserts ready", 64'(miss_ready_o), 0);
    chk(mreq_valid_o == 1, "R2 reads pending while full", 64'(mreq_valid_o), 1);
    mem_block = 0;
    for (int i = 0; i < 40; i++) send_miss(rand_va(), 4'($urandom));
    while (n_done != n_sent) @(negedge clk);
    chk(n_done == 73, "R4 out-of-order walks all complete", 64'(n_done), 73);
    repeat (3) @(negedge clk);
    chk(miss_ready_o == 1, "R2 ready after drain", 64'(miss_ready_o), 1);

    // R6 round-robin among four contending walks
    mem_block = 1;
    for (int i = 0; i < 4; i++) send_miss(rand_va(), 4'(i));
    @(negedge clk);
    base_req = nreq;
    fast = 1;
    mem_block = 0;
    while (nreq < base_req + 8) @(negedge clk);
    distinct = 1;
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (log_t[base_req + i] == log_t[base_req + j]) distinct = 0;
    chk(distinct, "R6 first four grants distinct", 64'(log_t[base_req + 2]), 64'(log_t[base_req]));
    for (int i = 0; i < 4; i++) cnt[i] = 0;
    for (int i = 0; i < 8; i++) if (log_t[base_req + i] < 4) cnt[log_t[base_req + i]]++;
    for (int i = 0; i < 4; i++) chk(cnt[i] == 2, "R6 two grants per buffer", 64'(cnt[i]), 2);
    while (n_done != n_sent) @(negedge clk);
    fast = 0;

    // R7..R9 fault handling
    fa = 48'h1111_2222_3000;
    fg = 48'h4444_5555_6000;
    bad0 = entry_addr(fa, 3);
    bad1 = entry_addr(fg, 2);
    bad0_en = 1;
    bad1_en = 1;
    base_done = n_done;
    send_miss(fa, 4'd5);
    send_miss(fg, 4'd6);
    repeat (200) @(negedge clk);
    chk(fault_irq_o == 1, "R7 irq raised", 64'(fault_irq_o), 1);
    chk(fault_va_o == fa || fault_va_o == fg, "R7 fault address", 64'(fault_va_o), 64'(fa));
    chk(n_done == base_done, "R7 faulted walks not completed", 64'(n_done), 64'(base_done));
    f1 = fault_va_o;
    f2 = (f1 == fa) ? fg : fa;
    base_req = nreq;
    handler_done(f1 ^ 48'h0000_0010_0000);
    repeat (50) @(negedge clk);
    chk(fault_irq_o == 1 && fault_va_o == f1, "R8 mismatched done ignored", 64'(fault_va_o), 64'(f1));
    chk(nreq == base_req, "R8 mismatched done issues no read", 64'(nreq), 64'(base_req));
    handler_done(f1);
    chk(fault_irq_o == 0, "R8 irq low during second walk", 64'(fault_irq_o), 0);
    repeat (200) @(negedge clk);
    chk(nreq > base_req, "R8 second walk issued reads", 64'(nreq), 64'(base_req));
    chk(fault_irq_o == 1 && fault_va_o == f1, "R9 failed second walk re-raises", 64'(fault_va_o), 64'(f1));
    if (f1 == fa) bad0_en = 0; else bad1_en = 0;
    handler_done(f1);
    repeat (200) @(negedge clk);
    chk(n_done == base_done + 1, "R9 successful second walk completes", 64'(n_done), 64'(base_done + 1));
    chk(fault_irq_o == 1 && fault_va_o == f2, "R7 next fault takes register", 64'(fault_va_o), 64'(f2));
    if (f2 == fa) bad0_en = 0; else bad1_en = 0;
    handler_done(f2);
    repeat (200) @(negedge clk);
    chk(n_done == base_done + 2, "R9 second fault resolved", 64'(n_done), 64'(base_done + 2));
    chk(fault_irq_o == 0, "R9 register cleared", 64'(fault_irq_o), 0);

    // R5 scoreboard drained
    begin
      int left;
      left = 0;
      for (int i = 0; i < n_sent; i++) if (sb_v[i]) left++;
      chk(left == 0, "R5 every miss answered", 64'(left), 0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule